// File: doc/BRIEF.md
# Mirrored CPU Address Decoder

This block sits between an 8-bit processor with a 16-bit address bus and the resources of a game-console style memory map. It contains 2 KiB of work RAM and repeats it four times over the lowest 8 KiB of address space. It sends every other access to one of four external ports, each of which gets a select line and a local address:

- an eight-register video peripheral, repeated every eight bytes across its 8 KiB window;
- an audio and I/O register port;
- a save RAM port;
- a fixed 32 KiB program ROM port.

Cartridge offsets are zero-based. Write data and the write strobe are shared by all ports.

All reads are combinational: the byte appears on `cpu_rdata` in the same cycle the address and read strobe are presented. RAM writes take effect on the rising clock edge. A read from an address that reaches no target returns the last byte that was on the data bus, whether that byte came from a read or from a write. Writes to the ROM window are forwarded with their offset so that external logic can watch them. The block stores nothing for those writes.

Top module: `cpu_addr_decoder`

## Requirements
- R1: Addresses 0x0000–0x1FFF reach the internal 2048-byte RAM at index addr[10:0]. A byte written at 0x0010 reads back at 0x0810, 0x1010 and 0x1810. A byte written at 0x1FFF reads back at 0x07FF.
- R2: A RAM write with `cpu_wr` high is stored on the rising clock edge. A RAM read returns the stored byte combinationally in the same cycle.
- R3: Addresses 0x2000–0x3FFF assert `vid_sel`, with `vid_idx` = addr[2:0]. For example, 0x2008 gives index 0 and 0x3FFE gives index 6.
- R4: Addresses 0x4000–0x4017 assert `aio_sel`, with `aio_idx` = addr[4:0].
- R5: Addresses 0x4018–0x5FFF assert no select. A read there returns the last byte seen on the bus, which is the previous read data or the previous write data. A write there changes no RAM byte and drives no target.
- R6: Addresses 0x6000–0x7FFF assert `sav_sel`, with `sav_ofs` = addr − 0x6000.
- R7: Addresses 0x8000–0xFFFF assert `rom_sel`, with `rom_ofs` = addr − 0x8000; for example, 0x8004 gives offset 0x0004. A write there is forwarded with `rom_sel`, `tgt_wr` and `tgt_wdata`.
- R8: At most one of the external selects or the internal RAM enable is active at a time. When both `cpu_rd` and `cpu_wr` are low, no select is asserted.
- R9: After reset, the held bus value is 0x00, so a read from unmapped space before any other access returns 0x00.
- R10: A read of a mapped external target returns that port's read data on `cpu_rdata` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Read data to the CPU |
| tgt_wr | output | 1 | Write strobe forwarded to the external ports |
| tgt_wdata | output | 8 | Write data forwarded to the external ports |
| vid_sel | output | 1 | Video register port select |
| vid_idx | output | 3 | Video register index |
| vid_rdata | input | 8 | Video register read data |
| aio_sel | output | 1 | Audio/I/O port select |
| aio_idx | output | 5 | Audio/I/O register index |
| aio_rdata | input | 8 | Audio/I/O read data |
| sav_sel | output | 1 | Save RAM select |
| sav_ofs | output | 13 | Save RAM offset |
| sav_rdata | input | 8 | Save RAM read data |
| rom_sel | output | 1 | Program ROM select |
| rom_ofs | output | 15 | Program ROM offset |
| rom_rdata | input | 8 | Program ROM read data |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit data and an 11-bit RAM index. At these values, the vectors can land on the exact edges of every window: 0x1FFF/0x2000, 0x4017/0x4018, 0x5FFF/0x6000 and 0x7FFF/0x8000. Each external port returns a distinct constant, so a wrong route shows up as a wrong byte. The unmapped reads are ordered so that the held value visibly follows both the previous read and the previous write.

// File: rtl/cad_pkg.sv
package cad_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] RAM_END  = 16'h1FFF;
  localparam logic [ADDR_W-1:0] VID_BASE = 16'h2000;
  localparam logic [ADDR_W-1:0] VID_END  = 16'h3FFF;
  localparam logic [ADDR_W-1:0] AIO_BASE = 16'h4000;
  localparam logic [ADDR_W-1:0] AIO_END  = 16'h4017;
  localparam logic [ADDR_W-1:0] SAV_BASE = 16'h6000;
  localparam logic [ADDR_W-1:0] SAV_END  = 16'h7FFF;
  localparam logic [ADDR_W-1:0] ROM_BASE = 16'h8000;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_RAM,
    TGT_VID,
    TGT_AIO,
    TGT_SAV,
    TGT_ROM
  } tgt_e;
endpackage

// File: rtl/cad_region_decode.sv
module cad_region_decode
  import cad_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt
);
  always_comb begin
    if (addr <= RAM_END)                         tgt = TGT_RAM;
    else if (addr >= VID_BASE && addr <= VID_END) tgt = TGT_VID;
    else if (addr >= AIO_BASE && addr <= AIO_END) tgt = TGT_AIO;
    else if (addr >= SAV_BASE && addr <= SAV_END) tgt = TGT_SAV;
    else if (addr >= ROM_BASE)                   tgt = TGT_ROM;
    else                                         tgt = TGT_NONE;
  end
endmodule

// File: rtl/cad_work_ram.sv
module cad_work_ram #(
  parameter int IDX_W = 11,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

  // R2: a stored byte is visible at the same index on the next cycle
  p_ram_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (idx != $past(idx) || rdata == $past(wdata)));
endmodule

// File: rtl/cad_bus_hold.sv
module cad_bus_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] rd_bus,
  input  logic [DW-1:0] wr_bus,
  output logic [DW-1:0] held
);
  logic [DW-1:0] held_d;
  logic          held_en;

  always_comb begin
    held_en = rd | wr;
    held_d  = wr ? wr_bus : rd_bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= '0;
    else if (held_en) held <= held_d;
  end

  // R5: the held value only moves when the bus carries a transfer
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd | wr) |=> $stable(held));
endmodule

// File: rtl/cpu_addr_decoder.sv
module cpu_addr_decoder
  import cad_pkg::*;
#(
  parameter int RAM_IDX_W = 11,
  parameter int VID_IDX_W = 3,
  parameter int AIO_IDX_W = 5,
  parameter int SAV_OFS_W = 13,
  parameter int ROM_OFS_W = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  input  logic                 cpu_rd,
  input  logic                 cpu_wr,
  output logic [DATA_W-1:0]    cpu_rdata,
  output logic                 tgt_wr,
  output logic [DATA_W-1:0]    tgt_wdata,
  output logic                 vid_sel,
  output logic [VID_IDX_W-1:0] vid_idx,
  input  logic [DATA_W-1:0]    vid_rdata,
  output logic                 aio_sel,
  output logic [AIO_IDX_W-1:0] aio_idx,
  input  logic [DATA_W-1:0]    aio_rdata,
  output logic                 sav_sel,
  output logic [SAV_OFS_W-1:0] sav_ofs,
  input  logic [DATA_W-1:0]    sav_rdata,
  output logic                 rom_sel,
  output logic [ROM_OFS_W-1:0] rom_ofs,
  input  logic [DATA_W-1:0]    rom_rdata
);
  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  tgt_e tgt;
  logic access;
  logic ram_en;
  logic ram_we;
  logic [DATA_W-1:0] ram_rdata;
  logic [DATA_W-1:0] held;

  cad_region_decode i_decode (
    .addr (cpu_addr),
    .tgt  (tgt)
  );

  always_comb begin
    access  = cpu_rd | cpu_wr;
    ram_en  = access & (tgt == TGT_RAM);
    ram_we  = cpu_wr & (tgt == TGT_RAM);
    vid_sel = access & (tgt == TGT_VID);
    aio_sel = access & (tgt == TGT_AIO);
    sav_sel = access & (tgt == TGT_SAV);
    rom_sel = access & (tgt == TGT_ROM);
  end

  always_comb begin
    vid_idx   = cpu_addr[VID_IDX_W-1:0];
    aio_idx   = cpu_addr[AIO_IDX_W-1:0];
    sav_ofs   = cpu_addr[SAV_OFS_W-1:0];
    rom_ofs   = cpu_addr[ROM_OFS_W-1:0];
    tgt_wr    = cpu_wr;
    tgt_wdata = cpu_wdata;
  end

  cad_work_ram #(.IDX_W(RAM_IDX_W), .DW(DATA_W)) i_ram (
    .clk   (clk),
    .rst_n (rst_q_n),
    .we    (ram_we),
    .idx   (cpu_addr[RAM_IDX_W-1:0]),
    .wdata (cpu_wdata),
    .rdata (ram_rdata)
  );

  always_comb begin
    unique case (tgt)
      TGT_RAM: cpu_rdata = ram_rdata;
      TGT_VID: cpu_rdata = vid_rdata;
      TGT_AIO: cpu_rdata = aio_rdata;
      TGT_SAV: cpu_rdata = sav_rdata;
      TGT_ROM: cpu_rdata = rom_rdata;
      default: cpu_rdata = held;
    endcase
  end

  cad_bus_hold #(.DW(DATA_W)) i_hold (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .rd     (cpu_rd),
    .wr     (cpu_wr),
    .rd_bus (cpu_rdata),
    .wr_bus (cpu_wdata),
    .held   (held)
  );

  // R8: never two targets at once
  p_one_target_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({ram_en, vid_sel, aio_sel, sav_sel, rom_sel}));

  // R8: an idle bus drives no target
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(cpu_rd | cpu_wr) |-> !(vid_sel | aio_sel | sav_sel | rom_sel | ram_en));

  // R7: ROM select only in the upper half of the map
  p_rom_window_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    rom_sel |-> cpu_addr[ADDR_W-1]);

  // R6: save select only between its bounds
  p_sav_window_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    sav_sel |-> (cpu_addr >= SAV_BASE && cpu_addr <= SAV_END));

  // R5: an unmapped read returns what the bus carried on the previous transfer
  p_open_bus_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rst_q_n) && $past(cpu_rd | cpu_wr) && cpu_rd && !cpu_wr && tgt == TGT_NONE)
      |-> cpu_rdata == ($past(cpu_wr) ? $past(cpu_wdata) : $past(cpu_rdata)));
endmodule

// File: tb/test_cpu_addr_decoder.sv
module test_cpu_addr_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NVEC       = 16;

  // {addr[35:20], mask {rom,sav,aio,vid}[19:16], local index[15:0]}
  localparam logic [35:0] VEC [NVEC] = '{
    {16'h2000, 4'b0001, 16'h0000},
    {16'h2007, 4'b0001, 16'h0007},
    {16'h2008, 4'b0001, 16'h0000},
    {16'h3FFE, 4'b0001, 16'h0006},
    {16'h4000, 4'b0010, 16'h0000},
    {16'h4017, 4'b0010, 16'h0017},
    {16'h4018, 4'b0000, 16'h0000},
    {16'h401F, 4'b0000, 16'h0000},
    {16'h6000, 4'b0100, 16'h0000},
    {16'h4020, 4'b0000, 16'h0000},
    {16'h5FFF, 4'b0000, 16'h0000},
    {16'h7FFF, 4'b0100, 16'h1FFF},
    {16'h8000, 4'b1000, 16'h0000},
    {16'h8004, 4'b1000, 16'h0004},
    {16'hFFFC, 4'b1000, 16'h7FFC},
    {16'hC123, 4'b1000, 16'h4123}
  };

  localparam logic [7:0] VID_D = 8'hA1;
  localparam logic [7:0] AIO_D = 8'hB2;
  localparam logic [7:0] SAV_D = 8'hC3;
  localparam logic [7:0] ROM_D = 8'hD4;

  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_rd;
  logic        cpu_wr;
  logic [7:0]  cpu_rdata;
  logic        tgt_wr;
  logic [7:0]  tgt_wdata;
  logic        vid_sel;
  logic [2:0]  vid_idx;
  logic        aio_sel;
  logic [4:0]  aio_idx;
  logic        sav_sel;
  logic [12:0] sav_ofs;
  logic        rom_sel;
  logic [14:0] rom_ofs;

  int n_vec;
  int n_bad;
  logic [7:0] last_bus;

  cpu_addr_decoder i_cpu_addr_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_rdata (cpu_rdata),
    .tgt_wr    (tgt_wr),
    .tgt_wdata (tgt_wdata),
    .vid_sel   (vid_sel),
    .vid_idx   (vid_idx),
    .vid_rdata (VID_D),
    .aio_sel   (aio_sel),
    .aio_idx   (aio_idx),
    .aio_rdata (AIO_D),
    .sav_sel   (sav_sel),
    .sav_ofs   (sav_ofs),
    .sav_rdata (SAV_D),
    .rom_sel   (rom_sel),
    .rom_ofs   (rom_ofs),
    .rom_rdata (ROM_D)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, look a quarter period later
  task automatic bus_rd(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
    #(CLK_PERIOD/4);
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_rd = 1'b0; cpu_wr = 1'b1;
    #(CLK_PERIOD/4);
  endtask

  task automatic bus_idle();
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: idle bus, address in ROM space, nothing selected
    cpu_addr = 16'h8000;
    #(CLK_PERIOD/4);
    check("R8 idle", {vid_sel, aio_sel, sav_sel, rom_sel}, 4'b0000);

    // R9: first unmapped read after reset
    bus_rd(16'h5000);
    check("R9 reset hold", cpu_rdata, 8'h00);
    last_bus = 8'h00;

    // table walk: R3 R4 R5 R6 R7 R10
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] a;
      logic [3:0]  m;
      logic [15:0] x;
      logic [7:0]  ed;
      a = VEC[i][35:20]; m = VEC[i][19:16]; x = VEC[i][15:0];
      bus_rd(a);
      check("R3/R4/R6/R7 selects", {rom_sel, sav_sel, aio_sel, vid_sel}, m);
      unique case (m)
        4'b0001: begin check("R3 vid_idx", vid_idx, x); ed = VID_D; end
        4'b0010: begin check("R4 aio_idx", aio_idx, x); ed = AIO_D; end
        4'b0100: begin check("R6 sav_ofs", sav_ofs, x); ed = SAV_D; end
        4'b1000: begin check("R7 rom_ofs", rom_ofs, x); ed = ROM_D; end
        default: ed = last_bus;
      endcase
      check((m == 4'b0000) ? "R5 open bus" : "R10 rdata", cpu_rdata, ed);
      last_bus = ed;
    end

    // R1 R2: RAM mirroring
    bus_wr(16'h0010, 8'h5A);
    check("R8 ram write no ext sel", {vid_sel, aio_sel, sav_sel, rom_sel}, 4'b0000);
    bus_rd(16'h0810); check("R1 mirror 0x0810", cpu_rdata, 8'h5A);
    bus_rd(16'h1010); check("R1 mirror 0x1010", cpu_rdata, 8'h5A);
    bus_rd(16'h1810); check("R1 mirror 0x1810", cpu_rdata, 8'h5A);
    bus_wr(16'h1FFF, 8'h33);
    bus_rd(16'h07FF); check("R1 top byte", cpu_rdata, 8'h33);
    bus_wr(16'h01FF, 8'h77);
    bus_rd(16'h19FF); check("R2 stack page", cpu_rdata, 8'h77);
    bus_wr(16'h0123, 8'h11);
    bus_wr(16'h0123, 8'h22);
    bus_rd(16'h0923); check("R2 overwrite", cpu_rdata, 8'h22);

    // R5: unmapped write, no target, RAM untouched, held value follows write data
    bus_wr(16'h4810, 8'hEE);
    check("R5 unmapped write sel", {vid_sel, aio_sel, sav_sel, rom_sel}, 4'b0000);
    bus_rd(16'h4900); check("R5 hold after write", cpu_rdata, 8'hEE);
    bus_rd(16'h0010); check("R5 ram untouched", cpu_rdata, 8'h5A);
    bus_rd(16'h4018); check("R5 hold after read", cpu_rdata, 8'h5A);

    // R7: ROM write forwarded
    bus_wr(16'h9234, 8'h42);
    check("R7 rom write sel", {rom_sel, tgt_wr}, 2'b11);
    check("R7 rom write ofs", rom_ofs, 15'h1234);
    check("R7 rom write data", tgt_wdata, 8'h42);

    bus_idle();
    check("R8 idle after traffic", {vid_sel, aio_sel, sav_sel, rom_sel}, 4'b0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule